// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block moves single bytes across the monitor slot of a framed time-division link. Two handshake bits travel in every frame: a data-valid bit from the sender (MX, active low) and an acknowledge bit from the receiver (MR, active low). One pulse on `frameTick` marks each frame. On that pulse the controller samples the incoming MX, MR and data byte, and it updates the outgoing MX, MR and byte, which then hold until the next pulse.

A processor reaches the block through a small register bus with four byte-wide locations: control, transmit data, receive data, and status with the transmit-busy flag. To send a byte, software loads it and then sets the busy flag. The transmitter signals data present, waits for the far end's acknowledge, and closes the message with idle frames. If no acknowledge arrives, it aborts. The receiver captures each new byte, acknowledges it for one frame and detects the end of the message. Four event bits record what happened. Each can be masked by an enable, is cleared when read, and feeds a single interrupt line.

Top module: `mon_link`

## Requirements
- R1: After reset every register reads 0. The control register at address 0 holds mxCtl (bit 0), txIrqEn (bit 1), mrCtl (bit 2) and rxIrqEn (bit 3), and reads back what was written, with the upper bits reading 0.
- R2: After software writes a byte to address 1 and writes status (address 3) with bit 7 set, status bit 7 reads 1. At the next frame tick, mxOut goes to 0 and txByteOut carries the byte. Outgoing MX and MR change only on a frame tick.
- R3: While the transmitter waits, an incoming MR that is 1 at one tick and 0 at the next is an acknowledge. MX returns to 1 and status bit 2 is set. If no new byte has been written to address 1 within the next two ticks, status bit 7 clears at the second tick. If one has been written, that byte is sent next.
- R4: If incoming MR is sampled as 1 at two consecutive ticks while the transmitter waits for an acknowledge, the transfer aborts. Status bit 3 is set, status bit 7 clears and MX returns to 1.
- R5: When mxCtl is 0, mxOut stays 1. When mrCtl is 0, mrOut stays 1.
- R6: When incoming MX is 0 at a tick after being 1 at the previous tick, the incoming byte is stored (read at address 2). With mrCtl set, mrOut is 0 for exactly that one frame.
- R7: Inside a message, incoming MX sampled as 1 at two consecutive ticks ends the reception and sets status bit 1.
- R8: Status bit 0 (byte received) is set for every received byte when mrCtl is 1. When mrCtl is 0, it is set only for the first byte of a message.
- R9: rxIrqEn gates status bits 0 and 1, and txIrqEn gates status bits 2 and 3. A masked event is never recorded.
- R10: Reading address 3 returns the event bits and clears them. An event arriving in the same cycle as the read is kept. irq is 1 exactly when any event bit is set.
- R11: Status bit 7 is set only by a write with bit 7 set. Writing address 3 with bit 7 at 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameTick | input | 1 | One-cycle pulse per frame |
| mxIn | input | 1 | Incoming data-valid bit, active low |
| mrIn | input | 1 | Incoming acknowledge bit, active low |
| rxByteIn | input | DATA_W | Incoming monitor byte |
| mxOut | output | 1 | Outgoing data-valid bit |
| mrOut | output | 1 | Outgoing acknowledge bit |
| txByteOut | output | DATA_W | Outgoing monitor byte |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (clears events at address 3) |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational on busAddr |
| irq | output | 1 | OR of the recorded event bits |

## Verification
The bench builds the block with its defaults: 8-bit data, and abort and end-of-message windows of two frames each. A frame tick comes every fourth clock. Because the windows are short, an abort, the close of a message and a back-to-back second byte each take only a handful of frames, so all three are reached many times in one short run. Looping the outgoing bits back to the inputs lets the transmitter and receiver drive each other. Scripted MX and MR patterns reach the first-byte-only event rule and the masked cases.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_EOM} txState_e;

  typedef struct packed {
    logic rxIrqEn;
    logic mrCtl;
    logic txIrqEn;
    logic mxCtl;
  } monCfg_t;

  typedef struct packed {
    logic loadTx;
    logic doneTx;
    logic evAck;
    logic evAbort;
    logic captureRx;
    logic evRx;
    logic evEnd;
  } monStrobe_t;

  localparam int REG_CTRL = 0;
  localparam int REG_TXD  = 1;
  localparam int REG_RXD  = 2;
  localparam int REG_STAT = 3;

endpackage

// File: rtl/mon_link_ctrl.sv
module mon_link_ctrl
  import mon_pkg::*;
#(
  parameter int ABORT_FRAMES = 2,
  parameter int EOM_FRAMES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       mxIn,
  input  logic       mrIn,
  input  monCfg_t    cfg,
  input  logic       txActive,
  input  logic       txFull,
  output monStrobe_t strb,
  output logic       mxLine,
  output logic       mrLine
);

  localparam int CNT_MAX = (ABORT_FRAMES > EOM_FRAMES) ? ABORT_FRAMES : EOM_FRAMES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ABORT_LIM = CNT_W'(ABORT_FRAMES);
  localparam logic [CNT_W-1:0] EOM_LIM   = CNT_W'(EOM_FRAMES);

  txState_e         txState, txStateN;
  logic [CNT_W-1:0] txCnt, txCntN, rxCnt, rxCntN;
  logic [CNT_W-1:0] txInc, rxInc;
  logic             mxReg, mxRegN, mrReg, mrRegN;
  logic             prevMx, prevMr, inPkt, inPktN;
  logic             mrFall, mxFall;

  assign txInc  = txCnt + 1'b1;
  assign rxInc  = rxCnt + 1'b1;
  assign mrFall = prevMr & ~mrIn;
  assign mxFall = prevMx & ~mxIn;

  // transmit handshake
  always_comb begin
    strb     = '0;
    txStateN = txState;
    txCntN   = txCnt;
    mxRegN   = mxReg;
    mrRegN   = mrReg;
    rxCntN   = rxCnt;
    inPktN   = inPkt;
    if (frameTick) begin
      unique case (txState)
        TX_IDLE: if (txActive) begin
          strb.loadTx = 1'b1; mxRegN = 1'b0; txStateN = TX_WAIT; txCntN = '0;
        end
        TX_WAIT: if (mrFall) begin
          strb.evAck = 1'b1; mxRegN = 1'b1; txStateN = TX_EOM; txCntN = '0;
        end else if (mrIn) begin
          if (txInc == ABORT_LIM) begin
            strb.evAbort = 1'b1; mxRegN = 1'b1; txStateN = TX_IDLE; txCntN = '0;
          end else txCntN = txInc;
        end else txCntN = '0;
        default: if (txFull) begin
          strb.loadTx = 1'b1; mxRegN = 1'b0; txStateN = TX_WAIT; txCntN = '0;
        end else if (txInc == EOM_LIM) begin
          strb.doneTx = 1'b1; txStateN = TX_IDLE; txCntN = '0;
        end else txCntN = txInc;
      endcase
      // receive handshake
      if (mxFall) begin
        strb.captureRx = 1'b1;
        strb.evRx      = cfg.mrCtl | ~inPkt;
        mrRegN         = 1'b0;
        inPktN         = 1'b1;
        rxCntN         = '0;
      end else begin
        mrRegN = 1'b1;
        if (mxIn && inPkt) begin
          if (rxInc == EOM_LIM) begin
            strb.evEnd = 1'b1; inPktN = 1'b0; rxCntN = '0;
          end else rxCntN = rxInc;
        end else rxCntN = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
      rxCnt   <= '0;
      mxReg   <= 1'b1;
      mrReg   <= 1'b1;
      prevMx  <= 1'b1;
      prevMr  <= 1'b1;
      inPkt   <= 1'b0;
    end else begin
      txState <= txStateN;
      txCnt   <= txCntN;
      rxCnt   <= rxCntN;
      mxReg   <= mxRegN;
      mrReg   <= mrRegN;
      inPkt   <= inPktN;
      if (frameTick) begin
        prevMx <= mxIn;
        prevMr <= mrIn;
      end
    end
  end

  assign mxLine = cfg.mxCtl ? mxReg : 1'b1;
  assign mrLine = cfg.mrCtl ? mrReg : 1'b1;

  assert_frame_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> ($stable(mxReg) && $stable(mrReg)));

  assert_mr_one_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !mrReg) |=> mrReg);

endmodule

// File: rtl/mon_link_regs.sv
module mon_link_regs
  import mon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] rxByteIn,
  input  monStrobe_t        strb,
  output monCfg_t           cfg,
  output logic              txActive,
  output logic              txFull,
  output logic [DATA_W-1:0] txByteOut,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  localparam int EVT_W = 4;
  localparam int CFG_W = $bits(monCfg_t);

  logic [DATA_W-1:0] txData, rxData;
  logic [EVT_W-1:0]  evt, evtNext;
  logic selCtrl, selTx, selRx, selStat, setActive;

  assign selCtrl   = (busAddr == ADDR_W'(REG_CTRL));
  assign selTx     = (busAddr == ADDR_W'(REG_TXD));
  assign selRx     = (busAddr == ADDR_W'(REG_RXD));
  assign selStat   = (busAddr == ADDR_W'(REG_STAT));
  assign setActive = busWr & selStat & busWdata[DATA_W-1];

  always_comb begin
    evtNext = (busRd && selStat) ? '0 : evt;
    evtNext[0] = evtNext[0] | (strb.evRx    & cfg.rxIrqEn);
    evtNext[1] = evtNext[1] | (strb.evEnd   & cfg.rxIrqEn);
    evtNext[2] = evtNext[2] | (strb.evAck   & cfg.txIrqEn);
    evtNext[3] = evtNext[3] | (strb.evAbort & cfg.txIrqEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      txData    <= '0;
      rxData    <= '0;
      txByteOut <= '0;
      txFull    <= 1'b0;
      txActive  <= 1'b0;
      evt       <= '0;
    end else begin
      evt <= evtNext;
      if (strb.loadTx) begin
        txByteOut <= txData;
        txFull    <= 1'b0;
      end
      if (strb.captureRx) rxData <= rxByteIn;
      if (strb.evAbort || strb.doneTx) txActive <= 1'b0;
      if (busWr && selCtrl) cfg <= monCfg_t'(busWdata[CFG_W-1:0]);
      if (busWr && selTx) begin
        txData <= busWdata;
        txFull <= 1'b1;
      end
      if (setActive) txActive <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (selCtrl)      busRdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
    else if (selTx)   busRdata = txData;
    else if (selRx)   busRdata = rxData;
    else if (selStat) busRdata = {txActive, {(DATA_W-EVT_W-1){1'b0}}, evt};
  end

  assign irq = |evt;

  assert_rx_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evt[0]) |-> $past(cfg.rxIrqEn));

  assert_tx_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evt[2]) |-> $past(cfg.txIrqEn));

  assert_abort_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evAbort && !setActive) |=> !txActive);

  assert_ack_while_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.evAck |-> txActive);

endmodule

// File: rtl/mon_link.sv
module mon_link
  import mon_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 2,
  parameter int ABORT_FRAMES = 2,
  parameter int EOM_FRAMES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              mxIn,
  input  logic              mrIn,
  input  logic [DATA_W-1:0] rxByteIn,
  output logic              mxOut,
  output logic              mrOut,
  output logic [DATA_W-1:0] txByteOut,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  monCfg_t    cfg;
  monStrobe_t strb;
  logic       txActive, txFull;

  mon_link_ctrl #(
    .ABORT_FRAMES(ABORT_FRAMES),
    .EOM_FRAMES  (EOM_FRAMES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .mxIn(mxIn), .mrIn(mrIn), .cfg(cfg),
    .txActive(txActive), .txFull(txFull),
    .strb(strb), .mxLine(mxOut), .mrLine(mrOut)
  );

  mon_link_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .rxByteIn(rxByteIn), .strb(strb), .cfg(cfg),
    .txActive(txActive), .txFull(txFull), .txByteOut(txByteOut),
    .busRdata(busRdata), .irq(irq)
  );

endmodule

// File: tb/mon_link_tb.sv
`timescale 1ns/1ps
module mon_link_tb;

  localparam int ABORT_N = 2;
  localparam int EOM_N   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b0;
  logic loopOn = 1'b1;
  logic mxDrv = 1'b1, mrDrv = 1'b1;
  logic [7:0] rxDrv = '0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  wire  mxOut, mrOut, irq;
  wire  [7:0] txByteOut, busRdata;
  wire  mxInW = loopOn ? mxOut : mxDrv;
  wire  mrInW = loopOn ? mrOut : mrDrv;
  wire  [7:0] rxInW = loopOn ? txByteOut : rxDrv;

  always #5 clk = ~clk;

  mon_link u_dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .mxIn(mxInW), .mrIn(mrInW), .rxByteIn(rxInW),
    .mxOut(mxOut), .mrOut(mrOut), .txByteOut(txByteOut),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit started = 0, finished = 0;
  string curTag = "R1";

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int mCfg = 0, mTxData = 0, mRxData = 0, mEvt = 0, mTxByte = 0;
  int mTxSt = 0, mTxCnt = 0, mRxCnt = 0;
  bit mTxFull = 0, mActive = 0, mMx = 1, mMr = 1, mPrevMx = 1, mPrevMr = 1, mInPkt = 0;
  bit sTick, sMx, sMr, sWr, sRd, sRst;
  int sAddr, sWd, sRx;
  bit ld, dn, ack, abt, cap, erx, eend;

  always @(posedge clk) begin
    if (!sRst) begin
      mCfg = 0; mTxData = 0; mRxData = 0; mEvt = 0; mTxByte = 0;
      mTxSt = 0; mTxCnt = 0; mRxCnt = 0; mTxFull = 0; mActive = 0;
      mMx = 1; mMr = 1; mPrevMx = 1; mPrevMr = 1; mInPkt = 0;
    end else begin
      ld = 0; dn = 0; ack = 0; abt = 0; cap = 0; erx = 0; eend = 0;
      if (sTick) begin
        if (mTxSt == 0) begin
          if (mActive) begin ld = 1; mMx = 0; mTxSt = 1; mTxCnt = 0; end
        end else if (mTxSt == 1) begin
          if (mPrevMr && !sMr) begin ack = 1; mMx = 1; mTxSt = 2; mTxCnt = 0; end
          else if (sMr) begin
            mTxCnt++;
            if (mTxCnt == ABORT_N) begin abt = 1; mMx = 1; mTxSt = 0; mTxCnt = 0; end
          end else mTxCnt = 0;
        end else begin
          if (mTxFull) begin ld = 1; mMx = 0; mTxSt = 1; mTxCnt = 0; end
          else begin
            mTxCnt++;
            if (mTxCnt == EOM_N) begin dn = 1; mTxSt = 0; mTxCnt = 0; end
          end
        end
        if (mPrevMx && !sMx) begin
          cap = 1; erx = mCfg[2] || !mInPkt; mMr = 0; mInPkt = 1; mRxCnt = 0;
        end else begin
          mMr = 1;
          if (sMx && mInPkt) begin
            mRxCnt++;
            if (mRxCnt == EOM_N) begin eend = 1; mInPkt = 0; mRxCnt = 0; end
          end else mRxCnt = 0;
        end
        mPrevMx = sMx; mPrevMr = sMr;
      end
      if (ld) begin mTxByte = mTxData; mTxFull = 0; end
      if (cap) mRxData = sRx;
      if (abt || dn) mActive = 0;
      if (sRd && sAddr == 3) mEvt = 0;
      if (erx  && mCfg[3]) mEvt |= 1;
      if (eend && mCfg[3]) mEvt |= 2;
      if (ack  && mCfg[1]) mEvt |= 4;
      if (abt  && mCfg[1]) mEvt |= 8;
      if (sWr) begin
        if (sAddr == 0) mCfg = sWd & 8'h0F;
        if (sAddr == 1) begin mTxData = sWd; mTxFull = 1; end
        if (sAddr == 3 && sWd[7]) mActive = 1;
      end
    end
  end

  function automatic int expRd(input int a);
    case (a)
      0: return mCfg;
      1: return mTxData;
      2: return mRxData;
      default: return (int'(mActive) << 7) | mEvt;
    endcase
  endfunction

  // compare every cycle away from the edge, then capture inputs for the model
  always @(negedge clk) begin
    if (started) begin
      check("R5", "mxOut", mxOut, mCfg[0] ? int'(mMx) : 1);
      check("R6", "mrOut", mrOut, mCfg[2] ? int'(mMr) : 1);
      check("R2", "txByteOut", txByteOut, mTxByte);
      check("R10", "irq", irq, mEvt != 0);
      check(curTag, "busRdata", busRdata, expRd(busAddr));
    end
    sTick = frameTick; sMx = mxInW; sMr = mrInW; sRx = rxInW;
    sWr = busWr; sRd = busRd; sAddr = busAddr; sWd = busWdata; sRst = rstN;
    if (rstN) started = 1;
  end

  // frame tick every fourth cycle
  int tickCnt = 0;
  always begin
    @(posedge clk); #2;
    frameTick = (tickCnt == 3);
    tickCnt = (tickCnt + 1) % 4;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2; busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #2; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, input string tag, input int exp);
    @(posedge clk); #2; busAddr = a; busRd = 1'b1; curTag = tag;
    @(negedge clk); #1; check(tag, "read", busRdata, exp);
    @(posedge clk); #2; busRd = 1'b0;
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!frameTick);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    busRead(2'd0, "R1", 8'h00);
    busRead(2'd3, "R1", 8'h00);
    check("R1", "irq reset", irq, 0);
    // R1 control readback
    busWrite(2'd0, 8'hFF);
    busRead(2'd0, "R1", 8'h0F);
    // R2/R3/R6/R7 loopback single byte
    busWrite(2'd1, 8'hA5);
    busWrite(2'd3, 8'h80);
    busRead(2'd3, "R2", 8'h80);
    repeat (8) waitTick();
    busRead(2'd3, "R3", 8'h07);
    busRead(2'd2, "R6", 8'hA5);
    busRead(2'd3, "R10", 8'h00);
    check("R10", "irq after clear", irq, 0);
    // R3 second byte written during end-of-message window
    busWrite(2'd1, 8'h3C);
    busWrite(2'd3, 8'h80);
    repeat (3) waitTick();
    busWrite(2'd1, 8'h5A);
    repeat (8) waitTick();
    busRead(2'd2, "R3", 8'h5A);
    busRead(2'd3, "R7", 8'h07);
    // R4 abort: far end never acknowledges
    loopOn = 1'b0; mxDrv = 1'b1; mrDrv = 1'b1;
    busWrite(2'd1, 8'h11);
    busWrite(2'd3, 8'h80);
    repeat (5) waitTick();
    busRead(2'd3, "R4", 8'h08);
    // R5 forced idle MX, R11 write without bit 7
    busWrite(2'd0, 8'h0E);
    busWrite(2'd3, 8'h80);
    busWrite(2'd3, 8'h0F);
    busRead(2'd3, "R11", 8'h80);
    waitTick(); @(negedge clk); check("R5", "mxOut forced", mxOut, 1);
    waitTick(); @(negedge clk); check("R5", "mxOut forced", mxOut, 1);
    repeat (3) waitTick();
    busRead(2'd3, "R4", 8'h08);
    // R8 first-byte-only events with MR forced idle
    busWrite(2'd0, 8'h09);
    mxDrv = 1'b1; rxDrv = 8'h21; waitTick();
    mxDrv = 1'b0; waitTick();
    busRead(2'd3, "R8", 8'h01);
    busRead(2'd2, "R6", 8'h21);
    check("R5", "mrOut forced", mrOut, 1);
    mxDrv = 1'b1; waitTick();
    mxDrv = 1'b0; rxDrv = 8'h22; waitTick();
    busRead(2'd3, "R8", 8'h00);
    busRead(2'd2, "R6", 8'h22);
    mxDrv = 1'b1; waitTick(); waitTick();
    busRead(2'd3, "R7", 8'h02);
    // R9 all events masked
    busWrite(2'd0, 8'h05);
    loopOn = 1'b1;
    busWrite(2'd1, 8'h77);
    busWrite(2'd3, 8'h80);
    repeat (8) waitTick();
    check("R9", "irq masked", irq, 0);
    busRead(2'd3, "R9", 8'h00);
    busRead(2'd2, "R6", 8'h77);
    repeat (4) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule